// File: doc/BRIEF.md
# Codec-Side Serial Link Input Frame Transmitter

This block is the codec end of a fixed-rate, time-multiplexed audio serial link. It drives the single data line that carries information from the codec back to the link controller. A frame has 256 bit periods: a 16-bit tag slot, then twelve 20-bit slots. The tag slot says whether the codec is ready and which of the later slots carry valid data. Slot 1 and slot 2 return the index and the contents of a register that the controller asked to read. Slots 3 and 4 carry the left and right recording samples. All other slots are zero.

A frame starts when the frame-sync input rises. The first tag bit goes out on the bit-clock rising edge at which the rise is first seen. This is the edge after the falling edge that would have sampled it. After that, one bit goes out on every rising edge, MSB first within each slot.

A register read request arrives from the output-side decoder while a frame is in progress. The block holds that request. At the next frame start it drives the index onto a register read port. It takes the returned word, or zero if the index is not implemented, and sends the response in that frame only.

The recording samples, the ADC power state and the codec-ready flag are taken once, at frame start. While the link is powered down or held tri-stated for test, the line is driven low and the bit sequencer is held idle.

Top module: `ac_link_in_tx`

## Requirements
- R1: Tag slot layout, bit 15 sent first. Bit 15 = codec ready. Bits 14 and 13 = slot 1 and slot 2 valid. Bits 12 and 11 = left and right sample valid. Bits 10 to 0 are 0.
- R2: When codec ready is sampled 0 at frame start, every bit after bit 15 of that frame is 0.
- R3: A read request (`rd_req` high for one cycle with `rd_idx`) seen during frame N is answered in frame N+1. That frame sets tag bits 14 and 13. Slot 1 carries the 7-bit index in bits 18:12. Slot 2 carries the 16-bit word in bits 19:4. All other bits of both slots are 0. `reg_rd_addr` holds the index from the frame start on, and the port data is taken on the second bit clock after frame start.
- R4: A read response is flagged valid for one frame only. The next frame clears tag bits 14 and 13 and sends slots 1 and 2 as zero, unless a new request arrived.
- R5: If `reg_hit` is low for the requested index, slot 2 carries 0000h whatever `reg_rd_data` holds, and tag bits 14 and 13 are still set.
- R6: With `adc_on` high at frame start, slot 3 carries the left sample and slot 4 the right sample. Each 18-bit sample sits in bits 19:2, MSB first, with bits 1:0 at 0. Tag bits 12 and 11 are set.
- R7: With `adc_on` low at frame start, tag bits 12 and 11 are 0 and slots 3 and 4 are all zero.
- R8: Slots 5 to 12 are always all zero.
- R9: The first bit of a frame is on `sdata_in` after the rising edge at which `sync` is first seen high. One bit follows per edge, 256 in all. The line then stays 0 until the next `sync` rise.
- R10: While `link_off` is high, `sdata_in` is 0 from the next edge on, any frame in progress is abandoned, and a `sync` rise does not start a frame. After release, nothing is sent until a new `sync` rise.
- R11: Synchronous reset drives `sdata_in` to 0 and drops any pending read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; data launched on rising edges |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Frame sync from the controller; its rise starts a frame |
| link_off | input | 1 | Link powered down or outputs held for test |
| codec_ready | input | 1 | Codec ready status, taken at frame start |
| rd_req | input | 1 | One-cycle pulse: controller asked for a register read |
| rd_idx | input | 7 | Index of the requested register |
| reg_rd_addr | output | 7 | Index presented to the register read port |
| reg_rd_data | input | 16 | Word returned by the register read port |
| reg_hit | input | 1 | High when `reg_rd_addr` names an implemented register |
| adc_on | input | 1 | Recording converter powered and valid |
| adc_left | input | 18 | Left recording sample, two's complement |
| adc_right | input | 18 | Right recording sample, two's complement |
| sdata_in | output | 1 | Serial data toward the controller |

## Verification
The bench goes after read timing. It places a request in one frame and checks that the answer shows up only in the next. A design that answers in the same frame, or that keeps the valid flags set, fails the slot 1/2 and tag comparisons in the following frame.

An unimplemented index is read while the port carries a non-zero word. A design that passes that word through instead of zero is caught. A frame with codec ready low follows a pending response, which catches any leak of response or sample bits through the ready gate.

The link is switched off part-way through a frame and released while sync stays low. A sequencer that resumes mid-frame would put bits on the line here. A reset with a pending request catches a design that keeps the stale request.

// File: rtl/acin_pkg.sv
package acin_pkg;
  localparam int TAG_W     = 16;
  localparam int SLOT_W    = 20;
  localparam int NUM_SLOTS = 13;
  localparam int BITNUM_W  = $clog2(SLOT_W);
  localparam int SLOTNUM_W = $clog2(NUM_SLOTS);
  localparam int FRAME_LEN = TAG_W + (NUM_SLOTS - 1) * SLOT_W;
  // slot numbers whose content the block produces
  localparam int SLOT_IDX  = 1;
  localparam int SLOT_DATA = 2;
  localparam int SLOT_LEFT = 3;
  localparam int SLOT_RIGHT = 4;
endpackage

// File: rtl/acin_start_detect.sv
module acin_start_detect (
  input  logic clk,
  input  logic rst,
  input  logic sync,
  input  logic link_off,
  output logic frame_start
);
  logic sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 1'b0;
    else     sync_q <= sync;
  end

  // a rise seen at this edge corresponds to the falling-edge sample of the rise
  assign frame_start = sync & ~sync_q & ~link_off & ~rst;
endmodule

// File: rtl/acin_read_tracker.sv
module acin_read_tracker #(
  parameter int IDX_W  = 7,
  parameter int REG_W  = 16,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [REG_W-1:0] reg_rd_data,
  input  logic             reg_hit,
  output logic [IDX_W-1:0] rsp_idx,
  output logic             rsp_valid,
  output logic [REG_W-1:0] rsp_data
);
  logic             pend_v;
  logic [IDX_W-1:0] pend_idx;
  logic [RD_LAT-1:0] fetch_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v     <= 1'b0;
      pend_idx   <= '0;
      rsp_valid  <= 1'b0;
      rsp_idx    <= '0;
      rsp_data   <= '0;
      fetch_pipe <= '0;
    end else begin
      fetch_pipe <= {fetch_pipe[RD_LAT-2:0], frame_start};
      if (frame_start) begin
        rsp_valid <= pend_v;
        rsp_idx   <= pend_idx;
        pend_v    <= rd_req;
        if (rd_req) pend_idx <= rd_idx;
      end else if (rd_req) begin
        pend_v   <= 1'b1;
        pend_idx <= rd_idx;
      end
      if (fetch_pipe[RD_LAT-1])
        rsp_data <= reg_hit ? reg_rd_data : '0;
    end
  end
endmodule

// File: rtl/acin_frame_ctl.sv
module acin_frame_ctl
  import acin_pkg::*;
#(
  parameter int ADC_W = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_start,
  input  logic                 link_off,
  input  logic                 codec_ready,
  input  logic                 adc_on,
  input  logic [2*ADC_W-1:0]   adc_pair,
  output logic                 active,
  output logic [SLOTNUM_W-1:0] slot_num,
  output logic [BITNUM_W-1:0]  bit_num,
  output logic                 ready_f,
  output logic                 adc_v,
  output logic [2*ADC_W-1:0]   samples_f
);
  localparam logic [SLOTNUM_W-1:0] LAST_SLOT = SLOTNUM_W'(NUM_SLOTS - 1);
  localparam logic [BITNUM_W-1:0]  SLOT_TOP  = BITNUM_W'(SLOT_W - 1);
  localparam logic [BITNUM_W-1:0]  TAG_NEXT  = BITNUM_W'(TAG_W - 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      slot_num <= '0;
      bit_num  <= '0;
      ready_f  <= 1'b0;
      adc_v    <= 1'b0;
    end else if (frame_start) begin
      active   <= 1'b1;
      slot_num <= '0;
      bit_num  <= TAG_NEXT;
      ready_f  <= codec_ready;
      adc_v    <= adc_on;
    end else if (link_off) begin
      active   <= 1'b0;
      slot_num <= '0;
      bit_num  <= '0;
    end else if (active) begin
      if (bit_num == '0) begin
        if (slot_num == LAST_SLOT) begin
          active <= 1'b0;
        end else begin
          slot_num <= slot_num + 1'b1;
          bit_num  <= SLOT_TOP;
        end
      end else begin
        bit_num <= bit_num - 1'b1;
      end
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst)
        samples_f[ch*ADC_W +: ADC_W] <= '0;
      else if (frame_start)
        samples_f[ch*ADC_W +: ADC_W] <= adc_pair[ch*ADC_W +: ADC_W];
    end
  end
endmodule

// File: rtl/acin_slot_mux.sv
module acin_slot_mux
  import acin_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int REG_W = 16,
  parameter int ADC_W = 18
) (
  input  logic [SLOTNUM_W-1:0] slot_num,
  input  logic [BITNUM_W-1:0]  bit_num,
  input  logic                 ready_f,
  input  logic                 rsp_valid,
  input  logic [IDX_W-1:0]     rsp_idx,
  input  logic [REG_W-1:0]     rsp_data,
  input  logic                 adc_v,
  input  logic [2*ADC_W-1:0]   samples_f,
  output logic                 bit_val
);
  localparam int IDX_HI = SLOT_W - 2;

  logic [SLOT_W-1:0] word;

  always_comb begin
    word = '0;
    case (int'(slot_num))
      0: begin
        word[TAG_W-1] = ready_f;
        word[TAG_W-2] = rsp_valid;
        word[TAG_W-3] = rsp_valid;
        word[TAG_W-4] = adc_v;
        word[TAG_W-5] = adc_v;
      end
      SLOT_IDX:   if (rsp_valid) word[IDX_HI -: IDX_W]   = rsp_idx;
      SLOT_DATA:  if (rsp_valid) word[SLOT_W-1 -: REG_W] = rsp_data;
      SLOT_LEFT:  if (adc_v) word[SLOT_W-1 -: ADC_W] = samples_f[0 +: ADC_W];
      SLOT_RIGHT: if (adc_v) word[SLOT_W-1 -: ADC_W] = samples_f[ADC_W +: ADC_W];
      default:    word = '0;
    endcase
    bit_val = ready_f & word[bit_num];
  end
endmodule

// File: rtl/ac_link_in_tx.sv
module ac_link_in_tx
  import acin_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int REG_W = 16,
  parameter int ADC_W = 18
) (
  input  logic             bit_clk,
  input  logic             rst,
  input  logic             sync,
  input  logic             link_off,
  input  logic             codec_ready,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] reg_rd_addr,
  input  logic [REG_W-1:0] reg_rd_data,
  input  logic             reg_hit,
  input  logic             adc_on,
  input  logic [ADC_W-1:0] adc_left,
  input  logic [ADC_W-1:0] adc_right,
  output logic             sdata_in
);
  logic                 frame_start;
  logic                 active;
  logic [SLOTNUM_W-1:0] slot_num;
  logic [BITNUM_W-1:0]  bit_num;
  logic                 ready_f;
  logic                 adc_v;
  logic [2*ADC_W-1:0]   samples_f;
  logic                 rsp_valid;
  logic [IDX_W-1:0]     rsp_idx;
  logic [REG_W-1:0]     rsp_data;
  logic                 bit_val;

  acin_start_detect u_start (
    .clk(bit_clk), .rst(rst), .sync(sync), .link_off(link_off),
    .frame_start(frame_start)
  );

  acin_read_tracker #(.IDX_W(IDX_W), .REG_W(REG_W), .RD_LAT(2)) u_read (
    .clk(bit_clk), .rst(rst), .frame_start(frame_start),
    .rd_req(rd_req), .rd_idx(rd_idx),
    .reg_rd_data(reg_rd_data), .reg_hit(reg_hit),
    .rsp_idx(rsp_idx), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  acin_frame_ctl #(.ADC_W(ADC_W)) u_ctl (
    .clk(bit_clk), .rst(rst), .frame_start(frame_start), .link_off(link_off),
    .codec_ready(codec_ready), .adc_on(adc_on),
    .adc_pair({adc_right, adc_left}),
    .active(active), .slot_num(slot_num), .bit_num(bit_num),
    .ready_f(ready_f), .adc_v(adc_v), .samples_f(samples_f)
  );

  acin_slot_mux #(.IDX_W(IDX_W), .REG_W(REG_W), .ADC_W(ADC_W)) u_mux (
    .slot_num(slot_num), .bit_num(bit_num), .ready_f(ready_f),
    .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_data(rsp_data),
    .adc_v(adc_v), .samples_f(samples_f), .bit_val(bit_val)
  );

  assign reg_rd_addr = rsp_idx;

  always_ff @(posedge bit_clk) begin
    if (rst || link_off) sdata_in <= 1'b0;
    else if (frame_start) sdata_in <= codec_ready;
    else if (active)      sdata_in <= bit_val;
    else                  sdata_in <= 1'b0;
  end
endmodule

// File: rtl/acin_checker.sv
module acin_checker
  import acin_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 link_off,
  input logic                 codec_ready,
  input logic                 sdata_in,
  input logic                 frame_start,
  input logic                 active,
  input logic                 ready_f,
  input logic [SLOTNUM_W-1:0] slot_num,
  input logic [IDX_W-1:0]     reg_rd_addr
);
  localparam logic [SLOTNUM_W-1:0] FIRST_ZERO_SLOT = SLOTNUM_W'(5);

  a_r10_off_quiet: assert property (@(posedge clk) disable iff (rst)
    link_off |=> !sdata_in);

  a_r9_first_bit: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (sdata_in == $past(codec_ready)));

  a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
    (!active && !frame_start) |=> !sdata_in);

  a_r2_not_ready_quiet: assert property (@(posedge clk) disable iff (rst)
    (active && !ready_f && !frame_start) |=> !sdata_in);

  a_r8_tail_zero: assert property (@(posedge clk) disable iff (rst)
    (active && !frame_start && slot_num >= FIRST_ZERO_SLOT) |=> !sdata_in);

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(reg_rd_addr));
endmodule

bind ac_link_in_tx acin_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(bit_clk), .rst(rst), .link_off(link_off), .codec_ready(codec_ready),
  .sdata_in(sdata_in), .frame_start(frame_start), .active(active),
  .ready_f(ready_f), .slot_num(slot_num), .reg_rd_addr(reg_rd_addr)
);

// File: tb/ac_link_in_tx_test.sv
module ac_link_in_tx_test;
  localparam int CLK_P = 10;
  localparam int IDX_W = 7;
  localparam int REG_W = 16;
  localparam int ADC_W = 18;
  localparam int NBITS = 256;
  localparam int NVEC  = 8;

  typedef struct packed {
    logic             rdy;
    logic             req;
    logic [IDX_W-1:0] idx;
    logic             adc;
    logic [ADC_W-1:0] l;
    logic [ADC_W-1:0] r;
  } vec_t;

  // each entry is one frame; a request made here is expected back in the next entry
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b1, 7'h04, 1'b1, 18'h25A5A, 18'h10F0F},
    '{1'b1, 1'b0, 7'h00, 1'b0, 18'h3FFFF, 18'h3FFFF},
    '{1'b1, 1'b1, 7'h13, 1'b1, 18'h00001, 18'h20000},
    '{1'b1, 1'b0, 7'h00, 1'b1, 18'h12345, 18'h2ABCD},
    '{1'b1, 1'b0, 7'h00, 1'b1, 18'h3C3C3, 18'h03C3C},
    '{1'b1, 1'b1, 7'h26, 1'b1, 18'h3FFFF, 18'h20000},
    '{1'b0, 1'b0, 7'h00, 1'b1, 18'h15555, 18'h2AAAA},
    '{1'b1, 1'b0, 7'h00, 1'b1, 18'h00F00, 18'h0F00F}
  };

  logic clk = 1'b0;
  logic rst, sync, link_off, codec_ready, rd_req, adc_on;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] reg_rd_addr;
  logic [REG_W-1:0] reg_rd_data;
  logic             reg_hit;
  logic [ADC_W-1:0] adc_left, adc_right;
  logic             sdata_in;
  logic [NBITS-1:0] cap;
  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic model_hit(input logic [IDX_W-1:0] a);
    return (a < 7'h40) && !a[0];
  endfunction

  function automatic logic [REG_W-1:0] model_data(input logic [IDX_W-1:0] a);
    return {a, ~a, 2'b01};
  endfunction

  assign reg_hit     = model_hit(reg_rd_addr);
  assign reg_rd_data = reg_hit ? model_data(reg_rd_addr) : 16'hDEAD;

  ac_link_in_tx #(.IDX_W(IDX_W), .REG_W(REG_W), .ADC_W(ADC_W)) uut (
    .bit_clk(clk), .rst(rst), .sync(sync), .link_off(link_off),
    .codec_ready(codec_ready), .rd_req(rd_req), .rd_idx(rd_idx),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data), .reg_hit(reg_hit),
    .adc_on(adc_on), .adc_left(adc_left), .adc_right(adc_right),
    .sdata_in(sdata_in)
  );

  task automatic check(input string what, input logic [19:0] got, input logic [19:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, got, exp);
    end
  endtask

  function automatic logic [19:0] slot_word(input int k);
    return cap[NBITS-1-16-(k-1)*20 -: 20];
  endfunction

  // called at a falling edge; sync rises here, 256 bits are sampled at falling edges
  task automatic run_frame(input int req_at, input logic [IDX_W-1:0] ridx,
                           input int off_at, input int on_at);
    sync = 1'b1;
    for (int i = 0; i < NBITS; i++) begin
      @(negedge clk);
      cap[NBITS-1-i] = sdata_in;
      if (i == 15) sync = 1'b0;
      if (i == req_at) begin rd_req = 1'b1; rd_idx = ridx; end
      if (i == req_at + 1) rd_req = 1'b0;
      if (i == off_at) link_off = 1'b1;
      if (i == on_at) link_off = 1'b0;
    end
  endtask

  task automatic check_frame(input logic rdy, input logic rv, input logic [IDX_W-1:0] ridx,
                             input logic av, input logic [ADC_W-1:0] l, input logic [ADC_W-1:0] r);
    logic [15:0] etag;
    logic [19:0] e1, e2, e3, e4;
    etag = rdy ? {rdy, rv, rv, av, av, 11'b0} : 16'h0;
    e1 = (rdy && rv) ? {1'b0, ridx, 12'b0} : 20'h0;
    e2 = (rdy && rv) ? {(model_hit(ridx) ? model_data(ridx) : 16'h0000), 4'b0} : 20'h0;
    e3 = (rdy && av) ? {l, 2'b00} : 20'h0;
    e4 = (rdy && av) ? {r, 2'b00} : 20'h0;
    check("R1/R2/R9 tag slot", {4'h0, cap[NBITS-1 -: 16]}, {4'h0, etag});
    check("R3/R4 slot1 index echo", slot_word(1), e1);
    check("R3/R5 slot2 read data", slot_word(2), e2);
    check("R6/R7 slot3 left", slot_word(3), e3);
    check("R6/R7 slot4 right", slot_word(4), e4);
    check("R8 slots 5-12 zero", {19'h0, |cap[NBITS-1-16-4*20:0]}, 20'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic             prev_req;
    logic [IDX_W-1:0] prev_idx;
    logic             any_high;
    rst = 1'b1; sync = 1'b0; link_off = 1'b0; codec_ready = 1'b0;
    rd_req = 1'b0; rd_idx = '0; adc_on = 1'b0; adc_left = '0; adc_right = '0;
    repeat (4) @(negedge clk);
    check("R11 output low in reset", {19'h0, sdata_in}, 20'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 idle low after reset", {19'h0, sdata_in}, 20'h0);

    prev_req = 1'b0; prev_idx = '0;
    for (int e = 0; e < NVEC; e++) begin
      codec_ready = VEC[e].rdy;
      adc_on      = VEC[e].adc;
      adc_left    = VEC[e].l;
      adc_right   = VEC[e].r;
      run_frame(VEC[e].req ? 100 : -1, VEC[e].idx, -1, -1);
      check_frame(VEC[e].rdy, prev_req, prev_idx, VEC[e].adc, VEC[e].l, VEC[e].r);
      prev_req = VEC[e].req;
      prev_idx = VEC[e].idx;
    end

    // R9: no new sync, line stays low
    any_high = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      any_high |= sdata_in;
    end
    check("R9 low after frame end", {19'h0, any_high}, 20'h0);

    // R10: link switched off mid-frame, released with sync low
    codec_ready = 1'b1; adc_on = 1'b1; adc_left = 18'h0AAAA; adc_right = 18'h15555;
    run_frame(-1, '0, 30, 40);
    check("R10 tag before link off", {4'h0, cap[NBITS-1 -: 16]}, {4'h0, 16'h9800});
    check("R10 quiet after link off", {19'h0, |cap[NBITS-1-31:0]}, 20'h0);
    run_frame(-1, '0, -1, -1);
    check_frame(1'b1, 1'b0, '0, 1'b1, 18'h0AAAA, 18'h15555);

    // R11: reset drops a pending read
    rd_req = 1'b1; rd_idx = 7'h08;
    @(negedge clk);
    rd_req = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 output low in mid-run reset", {19'h0, sdata_in}, 20'h0);
    rst = 1'b0;
    @(negedge clk);
    run_frame(-1, '0, -1, -1);
    check_frame(1'b1, 1'b0, '0, 1'b1, 18'h0AAAA, 18'h15555);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule